// File: doc/BRIEF.md
# Two-Bank In-Place Matrix Transpose Engine

This block holds a square matrix of 4-bit elements in a pair of storage banks, modelled as the upper and lower tiers of a stacked memory. A host loads and reads elements of the primary bank through a simple element port. After the host pulses `start`, the engine transposes the matrix in place in the primary bank. The run takes exactly N+1 cycles. In the first busy cycle the whole primary bank is copied, position for position, into the secondary bank in one parallel transfer. In each of the next N cycles, one column of the secondary bank is written back as the row of the same index in the primary bank.

Only square matrices are transposed. A rectangular operand is placed in the top-left corner of the array, with zeros in every other position, and its transpose then appears in the top-left corner with the zero padding kept. The primary bank clears to zero on reset, so positions that were never written read as zero. While a run is in progress the host port refuses every access and reports each refusal. The engine raises a one-cycle completion pulse when the last row has been written back.

Top module: `mtx_transpose_2bank`

## Requirements
- R1: After reset, `busy`, `done`, `host_rvalid` and `host_rej` are 0, and every element of the primary bank reads 0.
- R2: When `host_re` is high and `busy` is low at a clock edge, `host_rdata` holds the 4-bit element at (`host_row`, `host_col`) and `host_rvalid` is 1 in the following cycle. When `host_we` is high and `busy` is low, `host_wdata` is stored at that position.
- R3: A `start` sampled while idle raises `busy` in the next cycle, and `busy` then stays high for exactly N+1 consecutive cycles.
- R4: `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R5: After a run, the element at row r, column c of the primary bank equals the element that was at row c, column r before the run, for every r and c.
- R6: Diagonal elements (r = c) hold the same values after a run as before it.
- R7: Two runs in a row leave the primary bank equal to its contents before the first run.
- R8: A host write or read presented while `busy` is high is refused. A refused write changes no element, a refused read gives no `host_rvalid`, and `host_rej` is 1 in the next cycle.
- R9: A `start` raised while `busy` is high is ignored. The run in progress still ends after N+1 busy cycles, and no new run follows it.
- R10: A matrix of a rows and b columns (a, b ≤ N), placed in the top-left corner with zeros elsewhere, becomes a matrix of b rows and a columns in the top-left corner after a run. All other positions remain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transpose run (accepted only while idle) |
| busy | output | 1 | High for the N+1 cycles of a run |
| done | output | 1 | One-cycle pulse after the last writeback |
| host_we | input | 1 | Host element write request |
| host_re | input | 1 | Host element read request |
| host_row | input | $clog2(N) | Row index of the host access |
| host_col | input | $clog2(N) | Column index of the host access |
| host_wdata | input | W | Element value to write |
| host_rdata | output | W | Element read, valid when host_rvalid is 1 |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| host_rej | output | 1 | An access was refused in the previous cycle because busy was high |

## Verification
The bench uses N = 5, which is not a power of two, so an index counter that wraps on its bit width rather than on N would overrun the writeback phase and break the N+1 busy length. It reads back the whole array after every run, so a writeback that goes to the wrong row or takes a row of the secondary bank instead of a column shows up as off-diagonal mismatches. A writeback that is one cycle late or early shows up as a row that is stale or duplicated. A second run checks that the secondary bank is refreshed on each start and not reused from the previous run. Host writes and a repeated start are injected in the middle of a run: a design that lets a refused write through corrupts the restored matrix, and one that accepts the repeated start stays busy after `done`. A padded 2×4 operand confirms that the zero region survives the run.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  // Phase of the transpose sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_COPY = 2'd1,
    PH_WB   = 2'd2
  } mtx_phase_e;

  localparam int unsigned ELEM_W_DEF = 4;
  localparam int unsigned DIM_DEF    = 32;

endpackage

// File: rtl/mtx_seq.sv
module mtx_seq #(
  parameter int unsigned N = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output mtx_pkg::mtx_phase_e    phase,
  output logic [$clog2(N)-1:0]   wb_idx,
  output logic                   busy,
  output logic                   done
);
  import mtx_pkg::*;

  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  mtx_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             step_en;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_COPY;
          idx_d   = '0;
        end
      end
      PH_COPY: begin
        phase_d = PH_WB;
        idx_d   = '0;
      end
      PH_WB: begin
        if (idx_q == LAST_IDX) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign step_en = start | (phase_q != PH_IDLE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else if (step_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign phase  = phase_q;
  assign wb_idx = idx_q;
  assign busy   = (phase_q != PH_IDLE);
  assign done   = done_q;

endmodule

// File: rtl/mtx_bank_pri.sv
module mtx_bank_pri #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [$clog2(N)-1:0]            wr_row,
  input  logic [$clog2(N)-1:0]            wr_col,
  input  logic [W-1:0]                    wr_data,
  input  logic                            row_we,
  input  logic [$clog2(N)-1:0]            row_idx,
  input  logic [N-1:0][W-1:0]             row_data,
  input  logic [$clog2(N)-1:0]            rd_row,
  input  logic [$clog2(N)-1:0]            rd_col,
  output logic [W-1:0]                    rd_data,
  output logic [N-1:0][N-1:0][W-1:0]      all_data
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0][N-1:0][W-1:0] mem_q;

  for (genvar r = 0; r < N; r++) begin : g_row
    logic row_hit;
    logic host_row_hit;
    assign row_hit      = row_we & (row_idx == IDX_W'(r));
    assign host_row_hit = wr_en & (wr_row == IDX_W'(r));
    for (genvar c = 0; c < N; c++) begin : g_col
      logic cell_en;
      logic [W-1:0] cell_d;
      always_comb begin
        cell_en = 1'b0;
        cell_d  = mem_q[r][c];
        if (row_hit) begin
          cell_en = 1'b1;
          cell_d  = row_data[c];
        end else if (host_row_hit && (wr_col == IDX_W'(c))) begin
          cell_en = 1'b1;
          cell_d  = wr_data;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[r][c] <= '0;
        else if (cell_en) mem_q[r][c] <= cell_d;
      end
    end
  end

  assign rd_data  = mem_q[rd_row][rd_col];
  assign all_data = mem_q;

endmodule

// File: rtl/mtx_bank_sec.sv
module mtx_bank_sec #(
  parameter int unsigned N = 32,
  parameter int unsigned W = 4
) (
  input  logic                         clk,
  input  logic                         copy_en,
  input  logic [N-1:0][N-1:0][W-1:0]   src,
  input  logic [$clog2(N)-1:0]         col_idx,
  output logic [N-1:0][W-1:0]          col_data
);
  // Data storage only: every cell is fully overwritten before it is used.
  logic [N-1:0][N-1:0][W-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (copy_en) mem_q <= src;
  end

  for (genvar j = 0; j < N; j++) begin : g_col_tap
    assign col_data[j] = mem_q[j][col_idx];
  end

endmodule

// File: rtl/mtx_host_port.sv
module mtx_host_port #(
  parameter int unsigned W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          we,
  input  logic          re,
  input  logic [W-1:0]  rd_elem,
  output logic          wr_en,
  output logic [W-1:0]  rdata,
  output logic          rvalid,
  output logic          rej
);
  logic          rd_ok;
  logic          rvalid_d, rej_d;
  logic [W-1:0]  rdata_d;

  assign rd_ok = re & ~busy;
  assign wr_en = we & ~busy;

  always_comb begin
    rvalid_d = rd_ok;
    rej_d    = (we | re) & busy;
    rdata_d  = rd_ok ? rd_elem : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rej    <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rvalid_d;
      rej    <= rej_d;
      rdata  <= rdata_d;
    end
  end

endmodule

// File: rtl/mtx_transpose_2bank.sv
module mtx_transpose_2bank #(
  parameter int unsigned N = mtx_pkg::DIM_DEF,
  parameter int unsigned W = mtx_pkg::ELEM_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic [$clog2(N)-1:0]  host_row,
  input  logic [$clog2(N)-1:0]  host_col,
  input  logic [W-1:0]          host_wdata,
  output logic [W-1:0]          host_rdata,
  output logic                  host_rvalid,
  output logic                  host_rej
);
  import mtx_pkg::*;

  localparam int unsigned IDX_W = $clog2(N);

  mtx_phase_e                  phase;
  logic [IDX_W-1:0]            wb_idx;
  logic                        copy_en, row_we, host_wr_en;
  logic [W-1:0]                rd_elem;
  logic [N-1:0][N-1:0][W-1:0]  pri_all;
  logic [N-1:0][W-1:0]         sec_col;

  mtx_seq #(.N(N)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .phase  (phase),
    .wb_idx (wb_idx),
    .busy   (busy),
    .done   (done)
  );

  assign copy_en = (phase == PH_COPY);
  assign row_we  = (phase == PH_WB);

  mtx_host_port #(.W(W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .we      (host_we),
    .re      (host_re),
    .rd_elem (rd_elem),
    .wr_en   (host_wr_en),
    .rdata   (host_rdata),
    .rvalid  (host_rvalid),
    .rej     (host_rej)
  );

  mtx_bank_pri #(.N(N), .W(W)) u_pri (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_wr_en),
    .wr_row   (host_row),
    .wr_col   (host_col),
    .wr_data  (host_wdata),
    .row_we   (row_we),
    .row_idx  (wb_idx),
    .row_data (sec_col),
    .rd_row   (host_row),
    .rd_col   (host_col),
    .rd_data  (rd_elem),
    .all_data (pri_all)
  );

  mtx_bank_sec #(.N(N), .W(W)) u_sec (
    .clk      (clk),
    .copy_en  (copy_en),
    .src      (pri_all),
    .col_idx  (wb_idx),
    .col_data (sec_col)
  );

endmodule

// File: rtl/mtx_transpose_2bank_chk.sv
module mtx_transpose_2bank_chk #(
  parameter int unsigned N = 32
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic host_we,
  input logic host_re,
  input logic host_rvalid,
  input logic host_rej
);
  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  // R3: run length is exactly N+1 busy cycles
  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == N + 1));

  assert_run_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt <= N));

  assert_start_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R4: done follows the end of a run, one cycle wide
  assert_done_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: accesses during a run are refused and reported
  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_we || host_re) && busy) |=> (host_rej && !host_rvalid));

  // R2: read data valid only after an accepted read
  assert_rvalid_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(host_re && !busy));

endmodule

bind mtx_transpose_2bank mtx_transpose_2bank_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .host_we     (host_we),
  .host_re     (host_re),
  .host_rvalid (host_rvalid),
  .host_rej    (host_rej)
);

// File: tb/mtx_transpose_2bank_bench.sv
module mtx_transpose_2bank_bench;

  localparam int N      = 5;
  localparam int W      = 4;
  localparam int IDX_W  = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic             busy, done;
  logic             host_we, host_re;
  logic [IDX_W-1:0] host_row, host_col;
  logic [W-1:0]     host_wdata, host_rdata;
  logic             host_rvalid, host_rej;

  int n_tests;
  int n_fail;
  bit finished;
  int exp_m [N][N];
  int orig_m [N][N];

  mtx_transpose_2bank #(.N(N), .W(W)) u_mtx_transpose_2bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .host_we     (host_we),
    .host_re     (host_re),
    .host_row    (host_row),
    .host_col    (host_col),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .host_rej    (host_rej)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic write_elem(input int r, input int c, input int v);
    @(negedge clk);
    host_we    = 1'b1;
    host_row   = IDX_W'(r);
    host_col   = IDX_W'(c);
    host_wdata = W'(v);
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic read_elem(input int r, input int c, output int v, output bit vld);
    @(negedge clk);
    host_re  = 1'b1;
    host_row = IDX_W'(r);
    host_col = IDX_W'(c);
    @(negedge clk);
    host_re  = 1'b0;
    v   = int'(host_rdata);
    vld = host_rvalid;
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        int v;
        bit vld;
        read_elem(r, c, v, vld);
        chk(vld && (v == exp_m[r][c]), req, vld ? v : -1, exp_m[r][c]);
      end
    end
  endtask

  task automatic load_pattern(input int seed);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        exp_m[r][c] = (r * 3 + c * 7 + seed) % 16;
        write_elem(r, c, exp_m[r][c]);
      end
    end
  endtask

  task automatic model_transpose();
    int t [N][N];
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        t[r][c] = exp_m[c][r];
    exp_m = t;
  endtask

  // Run one transpose; when disturb is set, inject refused accesses and a repeated start
  task automatic run_transpose(input bit disturb);
    int cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    cnt = 1;
    while (busy && cnt < 4 * N) begin
      if (disturb && cnt == 2) begin
        host_we    = 1'b1;
        host_row   = IDX_W'(0);
        host_col   = IDX_W'(1);
        host_wdata = W'((exp_m[1][0] + 5) % 16);
        start      = 1'b1;
      end
      if (disturb && cnt == 4) begin
        host_re  = 1'b1;
        host_row = IDX_W'(1);
        host_col = IDX_W'(1);
      end
      @(negedge clk);
      if (disturb && (cnt == 2 || cnt == 4)) begin
        chk(host_rej == 1'b1, "R8 refusal flag", int'(host_rej), 1);
        chk(host_rvalid == 1'b0, "R8 no read data", int'(host_rvalid), 0);
      end
      host_we = 1'b0;
      host_re = 1'b0;
      start   = 1'b0;
      if (busy) cnt++;
    end
    chk(cnt == N + 1, "R3 busy length", cnt, N + 1);
    chk(done == 1'b1, "R4 done after run", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R4 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R9 no restart", int'(busy), 0);
    model_transpose();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    n_tests  = 0;
    n_fail   = 0;
    finished = 0;
    rst_n = 1'b0; start = 1'b0; host_we = 1'b0; host_re = 1'b0;
    host_row = '0; host_col = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(host_rvalid == 1'b0, "R1 rvalid", int'(host_rvalid), 0);
    chk(host_rej == 1'b0, "R1 rej", int'(host_rej), 0);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) exp_m[r][c] = 0;
    check_all("R1 cleared");

    // R2: load and read back
    load_pattern(1);
    check_all("R2 readback");

    // R5, R6: plain transpose
    orig_m = exp_m;
    run_transpose(1'b0);
    check_all("R5 transposed");
    for (int d = 0; d < N; d++) begin
      int v;
      bit vld;
      read_elem(d, d, v, vld);
      chk(vld && v == orig_m[d][d], "R6 diagonal", v, orig_m[d][d]);
    end

    // R7, R8, R9: second run with disturbances restores original
    run_transpose(1'b1);
    check_all("R7 R8 restored");
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        chk(exp_m[r][c] == orig_m[r][c], "R7 model", exp_m[r][c], orig_m[r][c]);

    // R5: more patterns, including all 16 element values
    for (int s = 2; s < 5; s++) begin
      load_pattern(s * 5);
      run_transpose(1'b0);
      check_all("R5 sweep");
    end

    // R10: 2x4 operand padded with zeros
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        exp_m[r][c] = (r < 2 && c < 4) ? ((r * 4 + c + 9) % 16) : 0;
        write_elem(r, c, exp_m[r][c]);
      end
    run_transpose(1'b0);
    check_all("R10 padded");
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (r >= 4 || c >= 2)
          chk(exp_m[r][c] == 0, "R10 pad region", exp_m[r][c], 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule